// File: doc/BRIEF.md
# Predicted Next-Fetch Address Unit

This block sits in the fetch stage and chooses the next program counter for each cycle, with no pipeline register of its own. The current fetch address and the group of instructions read for it come in. In the same cycle the block searches a direct-mapped branch target buffer and a table of two-bit saturating direction counters, once for every slot of the group. A target-buffer hit marks a slot as a branch and supplies its target. The direction counter alone decides whether that branch is predicted taken.

The first branch slot at or after the fetch address decides the outcome. If it is predicted taken, the younger slots of the group are killed and fetch continues at the stored target. Otherwise fetch continues at the start of the next aligned group. The back end drives two more inputs. A resolve input trains a counter on every resolved branch and writes the target buffer only on a resolved taken branch. A redirect input overrides every prediction in the same cycle.

Top module: `fetch_nextpc_unit`

## Requirements
- R1: After reset every target-buffer entry is invalid and every counter holds 1 (weakly not taken), so no fetch address is predicted taken until the first resolve.
- R2: With no redirect and no taken prediction, next_pc is the fetch address rounded down to a group boundary (GROUP*4 bytes) plus GROUP*4.
- R3: A target-buffer hit whose counter is 0 or 1 does not redirect. next_pc is the sequential address of R2, and no slot is killed for that branch.
- R4: When the deciding branch slot hits and its counter is 2 or 3, pred_taken is 1, next_pc is the stored target, and every slot after that branch reads 0 in slot_valid.
- R5: Only the lowest-addressed hitting slot at or after the fetch address decides. A later hit predicted taken is ignored when an earlier hit is predicted not taken.
- R6: On each resolve the counter at index pc[IDX+1:2] moves up by one on taken and down by one on not taken, and it saturates at 3 and at 0.
- R7: A resolve marked taken writes the valid bit, the tag and the target of the entry at pc[IDX+1:2]. A resolve marked not taken leaves the target buffer unchanged.
- R8: A lookup hits only when the stored tag equals the upper address bits of the slot. A taken resolve of an aliasing address replaces the older entry.
- R9: When redir_valid is 1, next_pc equals redir_pc, slot_valid is 0, pred_taken is 0 and issue_insn is 0, whatever the tables predict.
- R10: A resolve changes the tables at the clock edge that samples it. A lookup in that same cycle still sees the old contents.
- R11: The 32-bit word of slot i of issue_insn equals the word of slot i of fetch_insn when slot_valid[i] is 1, and is 0 otherwise. Slot i occupies bits [32*i+31:32*i].
- R12: Slots below the fetch address's slot offset (pc[SLOT_W+1:2]) read 0 in slot_valid, and a branch held in such a slot has no effect on the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Current fetch address |
| fetch_insn | input | 32*GROUP | Instructions read for the aligned group, slot 0 in the low bits |
| redir_valid | input | 1 | Back-end mispredict redirect |
| redir_pc | input | 32 | Redirect address |
| res_valid | input | 1 | A resolved branch is presented |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Resolved direction |
| res_target | input | 32 | Resolved target address |
| next_pc | output | 32 | Chosen next fetch address |
| slot_valid | output | GROUP | Slots passed to the back end |
| pred_taken | output | 1 | The deciding branch is predicted taken |
| issue_insn | output | 32*GROUP | Fetched instructions with killed slots zeroed |

## Verification
The bench builds the unit with GROUP=4, BTB_ENTRIES=8 and PHT_ENTRIES=16. These sizes make target-buffer aliasing 32 bytes apart and counter aliasing 64 bytes apart, so the tag-mismatch and replacement cases can be reached with a handful of nearby branch addresses. The addresses are chosen so that each scenario trains its own counters and does not disturb the others. This lets saturation at both ends, the first-branch rule, the start-offset masking and the override of a taken prediction by a redirect each be checked on known counter values.

// File: rtl/fnp_pkg.sv
package fnp_pkg;

    typedef logic [31:0] addr_t;
    typedef logic [1:0]  ctr_t;

    localparam ctr_t CTR_RESET = 2'd1;

    // direction predicted by a counter value
    function automatic logic ctr_says_taken(input ctr_t c);
        return c[1];
    endfunction

    // saturating step toward the resolved direction
    function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
        ctr_t r;
        if (taken) r = (c == 2'd3) ? c : c + 2'd1;
        else       r = (c == 2'd0) ? c : c - 2'd1;
        return r;
    endfunction

endpackage

// File: rtl/fnp_target_buf.sv
module fnp_target_buf
    import fnp_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int GROUP   = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t look_pc  [GROUP],
    output logic  look_hit [GROUP],
    output addr_t look_tgt [GROUP],
    input  logic  wr_en,
    input  addr_t wr_pc,
    input  addr_t wr_tgt
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = 32 - IDX_W - 2;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    addr_t              tgt_q [ENTRIES];

    logic [IDX_W-1:0] wr_idx;
    assign wr_idx = wr_pc[IDX_W+1:2];

    always_ff @(posedge clk) begin
        if (rst)        vld_q <= '0;
        else if (wr_en) vld_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_pc[31:IDX_W+2];
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    for (genvar s = 0; s < GROUP; s++) begin : g_look
        logic [IDX_W-1:0] idx;
        assign idx         = look_pc[s][IDX_W+1:2];
        assign look_hit[s] = vld_q[idx] && (tag_q[idx] == look_pc[s][31:IDX_W+2]);
        assign look_tgt[s] = tgt_q[idx];
    end

    // R7: without a taken resolve the valid bits never change
    assert_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(vld_q));

endmodule

// File: rtl/fnp_dir_table.sv
module fnp_dir_table
    import fnp_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int GROUP   = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t look_pc  [GROUP],
    output logic  look_tk  [GROUP],
    input  logic  upd_en,
    input  addr_t upd_pc,
    input  logic  upd_taken
);
    localparam int IDX_W = $clog2(ENTRIES);

    ctr_t ctr_q [ENTRIES];

    logic [IDX_W-1:0] upd_idx;
    assign upd_idx = upd_pc[IDX_W+1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) ctr_q[e] <= CTR_RESET;
        end else if (upd_en) begin
            ctr_q[upd_idx] <= ctr_step(ctr_q[upd_idx], upd_taken);
        end
    end

    for (genvar s = 0; s < GROUP; s++) begin : g_look
        assign look_tk[s] = ctr_says_taken(ctr_q[look_pc[s][IDX_W+1:2]]);
    end

    assert_sat_high_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_taken && ctr_q[upd_idx] == 2'd3) |=> (ctr_q[$past(upd_idx)] == 2'd3));

    assert_sat_low_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_taken && ctr_q[upd_idx] == 2'd0) |=> (ctr_q[$past(upd_idx)] == 2'd0));

endmodule

// File: rtl/fnp_slot_select.sv
module fnp_slot_select #(
    parameter int GROUP  = 4,
    parameter int SLOT_W = $clog2(GROUP)
) (
    input  logic [SLOT_W-1:0] start_slot,
    input  logic              hit [GROUP],
    input  logic              tk  [GROUP],
    output logic [GROUP-1:0]  keep,
    output logic              take,
    output logic [SLOT_W-1:0] sel
);
    always_comb begin
        logic found;
        logic in_range;
        found = 1'b0;
        take  = 1'b0;
        sel   = '0;
        keep  = '0;
        for (int s = 0; s < GROUP; s++) begin
            in_range = (SLOT_W'(s) >= start_slot);
            keep[s]  = in_range && !take;
            if (in_range && !found && hit[s]) begin
                found = 1'b1;
                sel   = SLOT_W'(s);
                take  = tk[s];
            end
        end
    end
endmodule

// File: rtl/fetch_nextpc_unit.sv
module fetch_nextpc_unit
    import fnp_pkg::*;
#(
    parameter int GROUP       = 4,
    parameter int BTB_ENTRIES = 16,
    parameter int PHT_ENTRIES = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [31:0]         fetch_pc,
    input  logic [GROUP*32-1:0] fetch_insn,
    input  logic                redir_valid,
    input  logic [31:0]         redir_pc,
    input  logic                res_valid,
    input  logic [31:0]         res_pc,
    input  logic                res_taken,
    input  logic [31:0]         res_target,
    output logic [31:0]         next_pc,
    output logic [GROUP-1:0]    slot_valid,
    output logic                pred_taken,
    output logic [GROUP*32-1:0] issue_insn
);
    localparam int SLOT_W = $clog2(GROUP);
    localparam int OFF_W  = SLOT_W + 2;

    addr_t             slot_pc  [GROUP];
    logic              slot_hit [GROUP];
    addr_t             slot_tgt [GROUP];
    logic              slot_tk  [GROUP];
    logic [GROUP-1:0]  keep;
    logic              take;
    logic [SLOT_W-1:0] sel;
    logic [SLOT_W-1:0] start_slot;
    addr_t             fall_pc;

    for (genvar s = 0; s < GROUP; s++) begin : g_slot_pc
        assign slot_pc[s] = {fetch_pc[31:OFF_W], SLOT_W'(s), 2'b00};
    end

    assign start_slot = fetch_pc[OFF_W-1:2];
    assign fall_pc    = {fetch_pc[31:OFF_W] + 1'b1, {OFF_W{1'b0}}};

    fnp_target_buf #(.ENTRIES(BTB_ENTRIES), .GROUP(GROUP)) u_tbuf (
        .clk      (clk),
        .rst      (rst),
        .look_pc  (slot_pc),
        .look_hit (slot_hit),
        .look_tgt (slot_tgt),
        .wr_en    (res_valid && res_taken),
        .wr_pc    (res_pc),
        .wr_tgt   (res_target)
    );

    fnp_dir_table #(.ENTRIES(PHT_ENTRIES), .GROUP(GROUP)) u_dir (
        .clk       (clk),
        .rst       (rst),
        .look_pc   (slot_pc),
        .look_tk   (slot_tk),
        .upd_en    (res_valid),
        .upd_pc    (res_pc),
        .upd_taken (res_taken)
    );

    fnp_slot_select #(.GROUP(GROUP), .SLOT_W(SLOT_W)) u_sel (
        .start_slot (start_slot),
        .hit        (slot_hit),
        .tk         (slot_tk),
        .keep       (keep),
        .take       (take),
        .sel        (sel)
    );

    always_comb begin
        if (redir_valid) begin
            next_pc    = redir_pc;
            slot_valid = '0;
            pred_taken = 1'b0;
        end else if (take) begin
            next_pc    = slot_tgt[sel];
            slot_valid = keep;
            pred_taken = 1'b1;
        end else begin
            next_pc    = fall_pc;
            slot_valid = keep;
            pred_taken = 1'b0;
        end
    end

    for (genvar s = 0; s < GROUP; s++) begin : g_issue
        assign issue_insn[s*32 +: 32] = slot_valid[s] ? fetch_insn[s*32 +: 32] : 32'h0;

        assert_issue_gate_R11: assert property (@(posedge clk) disable iff (rst)
            !slot_valid[s] |-> (issue_insn[s*32 +: 32] == 32'h0));
    end

    assert_redirect_R9: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (slot_valid == '0 && !pred_taken && next_pc == redir_pc));

    assert_start_slot_R12: assert property (@(posedge clk) disable iff (rst)
        !redir_valid |-> slot_valid[start_slot]);

    assert_below_start_R12: assert property (@(posedge clk) disable iff (rst)
        (!redir_valid && start_slot != '0) |-> !slot_valid[0]);

    assert_sequential_R2: assert property (@(posedge clk) disable iff (rst)
        (!redir_valid && !pred_taken) |-> (next_pc[OFF_W-1:0] == '0 && slot_valid[GROUP-1]));

endmodule

// File: tb/fetch_nextpc_unit_tb.sv
module fetch_nextpc_unit_tb;
    localparam int G = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   fetch_pc = '0;
    logic [G*32-1:0] fetch_insn = '0;
    logic          redir_valid = 1'b0;
    logic [31:0]   redir_pc = '0;
    logic          res_valid = 1'b0;
    logic [31:0]   res_pc = '0;
    logic          res_taken = 1'b0;
    logic [31:0]   res_target = '0;
    logic [31:0]   next_pc;
    logic [G-1:0]  slot_valid;
    logic          pred_taken;
    logic [G*32-1:0] issue_insn;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    fetch_nextpc_unit #(.GROUP(G), .BTB_ENTRIES(8), .PHT_ENTRIES(16)) u_dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_insn(fetch_insn),
        .redir_valid(redir_valid), .redir_pc(redir_pc),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .next_pc(next_pc), .slot_valid(slot_valid),
        .pred_taken(pred_taken), .issue_insn(issue_insn)
    );

    function automatic logic [G*32-1:0] mk_group(input logic [31:0] pc);
        logic [G*32-1:0] g;
        for (int s = 0; s < G; s++)
            g[s*32 +: 32] = 32'hC0DE_0000 | ({pc[31:4], 4'h0} + 32'(4*s));
        return g;
    endfunction

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare outputs for inputs already applied
    task automatic check_now(input string req, input logic [31:0] exp_next,
                             input logic [G-1:0] exp_mask, input logic exp_pt);
        #1;
        cmp(req, "next_pc", next_pc, exp_next);
        cmp(req, "slot_valid", 32'(slot_valid), 32'(exp_mask));
        cmp(req, "pred_taken", 32'(pred_taken), 32'(exp_pt));
        for (int s = 0; s < G; s++)
            cmp("R11", "issue_insn slot", issue_insn[s*32 +: 32],
                exp_mask[s] ? fetch_insn[s*32 +: 32] : 32'h0);
    endtask

    task automatic probe(input string req, input logic [31:0] pc, input logic [31:0] exp_next,
                         input logic [G-1:0] exp_mask, input logic exp_pt);
        @(negedge clk);
        fetch_pc   = pc;
        fetch_insn = mk_group(pc);
        check_now(req, exp_next, exp_mask, exp_pt);
    endtask

    task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic t_reset_state;
        probe("R1", 32'h100, 32'h110, 4'b1111, 1'b0);
        probe("R1", 32'h30C, 32'h310, 4'b1000, 1'b0);
    endtask

    task automatic t_sequential;
        probe("R2", 32'h208, 32'h210, 4'b1100, 1'b0);
        probe("R2", 32'hFFFF_FFF4, 32'h0, 4'b1110, 1'b0);
    endtask

    task automatic t_hit_then_taken;
        resolve(32'h304, 1'b1, 32'h400);   // ctr 2, entry written
        resolve(32'h304, 1'b0, 32'h0);     // ctr 1, entry kept
        probe("R3", 32'h300, 32'h310, 4'b1111, 1'b0);
        // R10: the taken resolve is pending in this cycle, old state seen
        @(negedge clk);
        res_valid = 1'b1; res_pc = 32'h304; res_taken = 1'b1; res_target = 32'h400;
        check_now("R10", 32'h310, 4'b1111, 1'b0);
        @(negedge clk);
        res_valid = 1'b0;
        fetch_insn = mk_group(32'h300);
        check_now("R4", 32'h400, 4'b0011, 1'b1);
    endtask

    task automatic t_first_branch;
        resolve(32'h324, 1'b1, 32'h500);
        resolve(32'h324, 1'b0, 32'h0);     // hit, ctr 1
        resolve(32'h32C, 1'b1, 32'h600);
        resolve(32'h32C, 1'b1, 32'h600);   // ctr 3
        probe("R5", 32'h320, 32'h330, 4'b1111, 1'b0);
        probe("R5", 32'h328, 32'h600, 4'b1100, 1'b1);
    endtask

    task automatic t_start_offset;
        resolve(32'h330, 1'b1, 32'h800);
        resolve(32'h330, 1'b1, 32'h800);
        probe("R4", 32'h330, 32'h800, 4'b0001, 1'b1);
        probe("R12", 32'h334, 32'h340, 4'b1110, 1'b0);
    endtask

    task automatic t_saturation;
        for (int k = 0; k < 4; k++) resolve(32'h354, 1'b1, 32'h900); // 3
        resolve(32'h354, 1'b0, 32'h0);                                 // 2
        probe("R6", 32'h350, 32'h900, 4'b0011, 1'b1);
        resolve(32'h354, 1'b0, 32'h0);                                 // 1
        probe("R6", 32'h350, 32'h360, 4'b1111, 1'b0);
        for (int k = 0; k < 3; k++) resolve(32'h354, 1'b0, 32'h0);    // 0
        resolve(32'h354, 1'b1, 32'h900);                               // 1
        probe("R6", 32'h350, 32'h360, 4'b1111, 1'b0);
        resolve(32'h354, 1'b1, 32'h900);                               // 2
        probe("R6", 32'h350, 32'h900, 4'b0011, 1'b1);
    endtask

    task automatic t_no_alloc_on_not_taken;
        resolve(32'h378, 1'b1, 32'hA00);
        resolve(32'h378, 1'b1, 32'hA00);   // ctr 3
        resolve(32'h378, 1'b0, 32'hB00);   // ctr 2, target must stay
        probe("R7", 32'h370, 32'hA00, 4'b0111, 1'b1);
    endtask

    task automatic t_tag_alias;
        probe("R8", 32'h390, 32'h3A0, 4'b1111, 1'b0);
        resolve(32'h398, 1'b1, 32'hC00);   // replaces entry of 0x378
        probe("R8", 32'h390, 32'hC00, 4'b0111, 1'b1);
        probe("R8", 32'h370, 32'h380, 4'b1111, 1'b0);
    endtask

    task automatic t_redirect;
        @(negedge clk);
        fetch_pc = 32'h330; fetch_insn = mk_group(32'h330);
        redir_valid = 1'b1; redir_pc = 32'h1234_5670;
        check_now("R9", 32'h1234_5670, 4'b0000, 1'b0);
        @(negedge clk);
        redir_valid = 1'b0;
        check_now("R9", 32'h800, 4'b0001, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_sequential();
        t_hit_then_taken();
        t_first_branch();
        t_start_offset();
        t_saturation();
        t_no_alloc_on_not_taken();
        t_tag_alias();
        t_redirect();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule